// File: doc/BRIEF.md
# Gated Synchronous-Start Clock Generator

This block derives a keyable square wave from a fast system clock. An active-low gate input decides when the wave runs. Every enable restarts the wave from the same phase, so the first output edge always comes a fixed number of system cycles after the gate falls. Disabling the gate stops the wave after the same fixed latency.

Two outputs are driven. While the block oscillates they carry the same waveform. While it is idle they rest at opposite levels: `clk_a` is low and `clk_b` is high. The half-period is a build-time parameter counted in system cycles.

After each stop the outputs must stay idle for at least one half-period. A gate fall that arrives inside that window is held until the window ends, and it is flagged by a single-cycle violation pulse.

Top module: `gated_clkgen`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the block returns to idle. After that edge `clk_a` is 0, `clk_b` is 1 and `recovery_violation` is 0.
- R2: The latency is LAT = SYNC_STAGES + EXTRA_DELAY + 2 rising edges. Take `gate_n` falling between two edges, with the recovery window expired. The outputs stay idle for the first LAT-1 rising edges that follow, and both go high on edge LAT.
- R3: While running, both outputs are high for HALF_PERIOD cycles, then low for HALF_PERIOD cycles, and repeat. Every run begins with the high half.
- R4: While running, `clk_a` equals `clk_b`. The combination `clk_a`=1, `clk_b`=0 never occurs.
- R5: Take `gate_n` rising between edges. On rising edge LAT after the rise, the outputs return at once to `clk_a`=0 and `clk_b`=1, even in the middle of a half-period.
- R6: A restart after any stop begins again with a full high half-period, whatever phase the previous run stopped in.
- R7: The outputs stay idle for at least HALF_PERIOD cycles between runs. Suppose the gate is high for G cycles, starting N cycles after the earlier fall. The second run then starts at cycle N + max(G, HALF_PERIOD) + LAT, counted from the earlier fall.
- R8: `recovery_violation` pulses high for exactly one cycle, on rising edge G+3 after the gate rise, if and only if 1 <= G < HALF_PERIOD. G is the number of cycles the gate stayed high.
- R9: A gate held low for N cycles, including N = 1, gives exactly N cycles of oscillation.
- R10: Reset leaves the recovery window expired. If `gate_n` is already low when reset is released, the outputs go high on rising edge LAT after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_n | input | 1 | Active-low run request, asynchronous to clk |
| clk_a | output | 1 | Generated clock; low when idle |
| clk_b | output | 1 | Generated clock; high when idle |
| recovery_violation | output | 1 | One-cycle flag: a gate fall came inside the recovery window |

## Verification
The assertions assume that reset is held low for at least two clock edges, so that the checker history starts from a known idle state. They also assume that `gate_n` settles well away from the sampling edge. The stimulus therefore changes the gate and the reset only on the falling clock edge. It also leaves more than a half-period of idle gate between independent scenarios, except in the recovery sweep, where gaps shorter than the window are applied on purpose.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
// Shared types for the gated clock generator.
// Assumes: none; holds only type definitions.
package gclk_pkg;

    // Control states: idle with the window expired, running, and waiting out the recovery window.
    typedef enum logic [1:0] {
        CTL_IDLE    = 2'd0,
        CTL_RUN     = 2'd1,
        CTL_RECOVER = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/gclk_sync.sv
`timescale 1ns/1ps
// Brings the asynchronous active-low gate into the clk domain and detects its falling edge.
// Assumes: SYNC_STAGES >= 2. Reset loads the stages high, which is the inactive gate level.
module gclk_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_n_async,
    output logic gate_n_sync,
    output logic gate_fell
);
    localparam int TOTAL = SYNC_STAGES + 1;

    logic [TOTAL-1:0] stage;

    // Shift the raw gate through the synchronizer chain plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '1;
        end else begin
            stage <= {stage[TOTAL-2:0], gate_n_async};
        end
    end

    assign gate_n_sync = stage[SYNC_STAGES-1];
    assign gate_fell   = stage[SYNC_STAGES] & ~stage[SYNC_STAGES-1];
endmodule

// File: rtl/gclk_ctrl.sv
`timescale 1ns/1ps
// Decides when the oscillator may run and enforces the post-stop recovery window.
// Assumes: gate_n_sync is already synchronous, and HALF_PERIOD >= 2.
module gclk_ctrl
    import gclk_pkg::*;
#(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_n_sync,
    input  logic gate_fell,
    output logic run_cmd,
    output logic violation
);
    localparam int CW = $clog2(HALF_PERIOD + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HALF_PERIOD - 1);

    ctl_state_t    state;
    logic [CW-1:0] rcnt;

    // Advance the state and count down the recovery window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CTL_IDLE;
            rcnt  <= '0;
        end else begin
            case (state)
                CTL_IDLE: begin
                    if (!gate_n_sync) state <= CTL_RUN;
                end
                CTL_RUN: begin
                    if (gate_n_sync) begin
                        state <= CTL_RECOVER;
                        rcnt  <= RELOAD;
                    end
                end
                CTL_RECOVER: begin
                    if (rcnt == '0) begin
                        state <= gate_n_sync ? CTL_IDLE : CTL_RUN;
                    end else begin
                        rcnt <= rcnt - 1'b1;
                    end
                end
                default: state <= CTL_IDLE;
            endcase
        end
    end

    // Flag a gate fall that has to be held off because the window is still open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            violation <= 1'b0;
        end else begin
            violation <= (state == CTL_RECOVER) && (rcnt != '0) && gate_fell;
        end
    end

    assign run_cmd = (state == CTL_RUN);
endmodule

// File: rtl/gclk_delay.sv
`timescale 1ns/1ps
// Delays the run command by a fixed number of cycles, so that start and stop share one latency.
// Assumes: DEPTH >= 0. The reset state is "not running".
module gclk_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (DEPTH == 0) begin : g_none
            assign q = d;
        end else if (DEPTH == 1) begin : g_one
            logic r;
            // Single stage of delay.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= 1'b0;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_many
            logic [DEPTH-1:0] sr;
            // Shift register of DEPTH stages.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[DEPTH-2:0], d};
            end
            assign q = sr[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/gclk_wave.sv
`timescale 1ns/1ps
// Square-wave generator. Each start begins in the high phase with a fresh count, and a stop forces the idle levels at once.
// Assumes: HALF_PERIOD >= 2, and run is synchronous.
module gclk_wave #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic out_a,
    output logic out_b
);
    localparam int PW = $clog2(HALF_PERIOD);
    localparam logic [PW-1:0] LAST = PW'(HALF_PERIOD - 1);

    logic          active;
    logic          phase;
    logic [PW-1:0] cnt;

    // Restart the phase on start, toggle each half-period, and clear on stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= 1'b0;
            cnt    <= '0;
        end else if (!run) begin
            active <= 1'b0;
            phase  <= 1'b0;
            cnt    <= '0;
        end else if (!active) begin
            active <= 1'b1;
            phase  <= 1'b1;
            cnt    <= '0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign out_a = phase;
    assign out_b = phase | ~active;
endmodule

// File: rtl/gated_clkgen.sv
`timescale 1ns/1ps
// Gated clock generator top. Chain: synchronizer, then control with recovery window, then latency line, then wave generator.
// Assumes: gate_n may be asynchronous. HALF_PERIOD >= 2. Start and stop latency is SYNC_STAGES + EXTRA_DELAY + 2 edges.
module gated_clkgen #(
    parameter int HALF_PERIOD = 4,
    parameter int SYNC_STAGES = 2,
    parameter int EXTRA_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_n,
    output logic clk_a,
    output logic clk_b,
    output logic recovery_violation
);
    logic gate_n_s;
    logic gate_fell;
    logic run_cmd;
    logic run_late;

    gclk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .gate_n_async(gate_n),
        .gate_n_sync(gate_n_s), .gate_fell(gate_fell)
    );

    gclk_ctrl #(.HALF_PERIOD(HALF_PERIOD)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .gate_n_sync(gate_n_s), .gate_fell(gate_fell),
        .run_cmd(run_cmd), .violation(recovery_violation)
    );

    gclk_delay #(.DEPTH(EXTRA_DELAY)) u_dly (
        .clk(clk), .rst_n(rst_n), .d(run_cmd), .q(run_late)
    );

    gclk_wave #(.HALF_PERIOD(HALF_PERIOD)) u_wave (
        .clk(clk), .rst_n(rst_n), .run(run_late), .out_a(clk_a), .out_b(clk_b)
    );
endmodule

// File: rtl/gated_clkgen_checker.sv
`timescale 1ns/1ps
// Port-level properties of the gated clock generator.
// Assumes: reset is held low for at least two edges before it is released.
module gated_clkgen_checker #(
    parameter int HALF_PERIOD = 4
) (
    input logic clk,
    input logic rst_n,
    input logic clk_a,
    input logic clk_b,
    input logic recovery_violation
);
    localparam int SW = $clog2(HALF_PERIOD + 2) + 1;

    logic          idle;
    logic          running;
    logic          run_q;
    logic          a_q;
    logic [SW-1:0] seg;
    logic [SW-1:0] idle_len;

    assign idle    = ~clk_a & clk_b;
    assign running = ~idle;

    // Track the previous output state, the current segment length and the idle length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            a_q      <= 1'b0;
            seg      <= '0;
            idle_len <= SW'(HALF_PERIOD);
        end else begin
            run_q <= running;
            a_q   <= clk_a;
            if (!running)                seg <= '0;
            else if (!run_q || clk_a != a_q) seg <= SW'(1);
            else if (seg != '1)          seg <= seg + 1'b1;
            if (running)                 idle_len <= '0;
            else if (idle_len != '1)     idle_len <= idle_len + 1'b1;
        end
    end

    assert_in_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_a && !clk_b));

    assert_start_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !run_q) |-> clk_a);

    assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_q && clk_a != a_q) |-> (seg == SW'(HALF_PERIOD)));

    assert_min_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !run_q) |-> (idle_len >= SW'(HALF_PERIOD)));

    assert_viol_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_violation |=> !recovery_violation);
endmodule

bind gated_clkgen gated_clkgen_checker #(.HALF_PERIOD(HALF_PERIOD)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b),
    .recovery_violation(recovery_violation)
);

// File: tb/sim_gated_clkgen.sv
`timescale 1ns/1ps
// Sweeps pulse widths and recovery gaps, and computes the expected waveforms arithmetically.
module sim_gated_clkgen;
    localparam int HP  = 3;
    localparam int SS  = 2;
    localparam int XD  = 2;
    localparam int LAT = SS + XD + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_n = 1'b1;
    logic clk_a, clk_b, recovery_violation;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    gated_clkgen #(.HALF_PERIOD(HP), .SYNC_STAGES(SS), .EXTRA_DELAY(XD)) u0 (
        .clk(clk), .rst_n(rst_n), .gate_n(gate_n),
        .clk_a(clk_a), .clk_b(clk_b), .recovery_violation(recovery_violation)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected {clk_a,clk_b} at sample k, given the run windows [s1,e1) and [s2,e2).
    function automatic logic [1:0] exp_out(int k, int s1, int e1, int s2, int e2);
        int s;
        if (k >= s1 && k < e1)      s = s1;
        else if (k >= s2 && k < e2) s = s2;
        else return 2'b01;
        return (((k - s) / HP) % 2 == 0) ? 2'b11 : 2'b00;
    endfunction

    // Gate low N cycles, high G cycles, then low M cycles (M = 0: a single pulse).
    task automatic scenario(input int n, input int g, input int m, input string tag);
        int s1, e1, s2, e2, total, hold;
        logic [1:0] e;
        bit ev;
        s1 = LAT; e1 = n + LAT;
        hold = (g > HP) ? g : HP;
        if (m > 0) begin s2 = n + hold + LAT; e2 = n + g + m + LAT; end
        else begin s2 = -1; e2 = -1; end
        total = n + g + m + LAT + HP + 6;
        for (int k = 0; k <= total; k++) begin
            @(negedge clk);
            e = exp_out(k, s1, e1, s2, e2);
            if (k < s1)                  check({clk_a, clk_b} == e, "R2", {clk_a, clk_b}, e);
            else if (k < e1)             check({clk_a, clk_b} == e, tag, {clk_a, clk_b}, e);
            else if (m > 0 && k < s2)    check({clk_a, clk_b} == e, "R7", {clk_a, clk_b}, e);
            else if (m > 0 && k < e2)    check({clk_a, clk_b} == e, "R6", {clk_a, clk_b}, e);
            else                         check({clk_a, clk_b} == e, "R5", {clk_a, clk_b}, e);
            if (clk_a | ~clk_b)          check(clk_a == clk_b, "R4", clk_a, clk_b);
            ev = (m > 0) && (g < HP) && (k == n + g + 3);
            check(recovery_violation == ev, "R8", recovery_violation, ev);
            if (k < n || (m > 0 && k >= n + g && k < n + g + m)) gate_n = 1'b0;
            else gate_n = 1'b1;
        end
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle levels under reset
        check(clk_a == 1'b0, "R1", clk_a, 0);
        check(clk_b == 1'b1, "R1", clk_b, 1);
        check(recovery_violation == 1'b0, "R1", recovery_violation, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R9 / R3: sweep the pulse width
        for (int n = 1; n <= 10; n++) scenario(n, 0, 0, (n < 4) ? "R9" : "R3");
        // R7 / R8: sweep the recovery gap
        for (int g = 1; g <= HP + 2; g++) scenario(7, g, 9, "R3");
        scenario(5, 2, 4, "R9");

        // R1: reset in the middle of a run forces the idle levels
        gate_n = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        check(clk_a == clk_b && clk_a == 1'b1, "R3", clk_a, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check({clk_a, clk_b} == 2'b01, "R1", {clk_a, clk_b}, 1);
        @(negedge clk);
        // R10: gate already low at reset release starts after LAT edges
        rst_n = 1'b1;
        for (int k = 0; k <= LAT + 4; k++) begin
            logic [1:0] e;
            if (k > 0) @(negedge clk);
            e = exp_out(k, LAT, 1000, -1, -1);
            check({clk_a, clk_b} == e, "R10", {clk_a, clk_b}, e);
        end
        gate_n = 1'b1;
        repeat (20) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule